// File: doc/BRIEF.md
# Periodic Serial Converter Capture Controller

This block is the master side of a three-wire link to an external serial analog-to-digital converter. It drives an active-low select and a serial clock, and it reads the converter's data line. An internal sample timer counts whole serial-clock periods and opens a frame at fixed intervals. Each frame lowers select for sixteen serial-clock periods and shifts in a 16-bit word, most significant bit first. The block then extracts the result for the chosen converter resolution and presents it on a one-cycle valid strobe.

The serial clock is the system clock divided by an even factor. The sample interval is programmed as a count of serial-clock periods, so the time between frame starts is always an exact multiple of the serial-clock period and samples are evenly spaced. A power-down request replaces the next frame with an eight-period burst, which puts the converter to sleep. The link then stays idle until a wake request arrives. The wake request issues one full frame whose result is thrown away, and normal sampling resumes after it.

Top module: `adc_capture_ctrl`

## Requirements
- R1: While reset is held and right after it is released, select and the serial clock are both high and the valid strobe is low.
- R2: A conversion frame holds select low for exactly 16 serial-clock periods and contains exactly 16 falling serial-clock edges.
- R3: The serial clock stays high whenever select is high. Inside a frame, each serial-clock period lasts DIV system clocks, with the high half first and the low half second.
- R4: The data line is sampled on each falling serial-clock edge, and the first bit sampled is bit 15 of the word. With resolution select 00 or 11, the result is word bits 11 down to 0.
- R5: Valid pulses for exactly one system clock, on the clock at which select returns high at the end of a conversion frame, and at no other time.
- R6: With resolution select 01, the result is word bits 11 down to 2, right-justified. With 10, it is word bits 11 down to 4, right-justified. The upper result bits are zero in both cases.
- R7: Consecutive conversion frames start exactly P*DIV system clocks apart, where P is the period input in serial-clock periods.
- R8: A period input below 17 acts as 17, so select is high for at least one serial-clock period between frames.
- R9: After a power-down request, the next frame slot issues a frame of exactly 8 serial-clock periods. No valid pulse follows it.
- R10: After the power-down frame, no frame starts until a wake request. A power-down request made while asleep is ignored.
- R11: After a wake request, the next slot issues a full 16-period frame with no valid pulse. The slots after it resume normal conversions with valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_i | input | PERIOD_W | Sample interval in serial-clock periods |
| res_sel_i | input | 2 | Resolution: 00/11 = 12 bit, 01 = 10 bit, 10 = 8 bit |
| pd_req_i | input | 1 | Power-down request pulse |
| wake_req_i | input | 1 | Wake request pulse |
| sdata_i | input | 1 | Serial data from converter |
| cs_n_o | output | 1 | Active-low converter select |
| sclk_o | output | 1 | Serial clock |
| smp_valid_o | output | 1 | One-cycle result strobe |
| smp_data_o | output | RES_W | Right-justified result |

## Verification
The bench builds the block with DIV = 4 and PERIOD_W = 8. The short serial-clock period lets dozens of frames fit in a brief run, and the 8-bit period field reaches intervals from below the clamp point (17) up to 40 periods. This makes the clamp, frame-to-frame spacing, and every resolution reachable under random period changes. A converter model counts falling edges per frame, so the 16-period and 8-period frame lengths and the sleep/wake sequence are checked at the pins.

// File: rtl/adc_capture_ctrl.sv
module adc_capture_ctrl #(
  parameter int DIV       = 8,
  parameter int PERIOD_W  = 10,
  parameter int FRAME_LEN = 16,
  parameter int PD_LEN    = 8,
  parameter int RES_W     = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [1:0]          res_sel_i,
  input  logic                pd_req_i,
  input  logic                wake_req_i,
  input  logic                sdata_i,
  output logic                cs_n_o,
  output logic                sclk_o,
  output logic                smp_valid_o,
  output logic [RES_W-1:0]    smp_data_o
);
  localparam int HALF    = DIV / 2;
  localparam int DIV_W   = $clog2(DIV);
  localparam int BIT_W   = $clog2(FRAME_LEN);
  localparam int MIN_PER = FRAME_LEN + 1;
  localparam int LO_W    = $clog2(FRAME_LEN * DIV + 1) + 1;

  typedef enum logic [1:0] {FK_DATA, FK_PD, FK_WAKE} kind_t;

  logic [DIV_W-1:0]     div_cnt;
  logic [PERIOD_W-1:0]  pcnt;
  logic [BIT_W-1:0]     bcnt;
  logic [FRAME_LEN-1:0] sr;
  logic                 act, sclk_q, asleep, pd_pend, wake_pend;
  kind_t                kind;

  wire tick = (div_cnt == DIV_W'(DIV - 1));
  wire fall = act && (div_cnt == DIV_W'(HALF - 1));
  wire [PERIOD_W-1:0] eff = (period_i < PERIOD_W'(MIN_PER)) ? PERIOD_W'(MIN_PER) : period_i;
  wire [BIT_W-1:0] last_bit = (kind == FK_PD) ? BIT_W'(PD_LEN - 1) : BIT_W'(FRAME_LEN - 1);
  wire [2:0] shamt = (res_sel_i == 2'b01) ? 3'd2 : (res_sel_i == 2'b10) ? 3'd4 : 3'd0;
  wire [RES_W-1:0] result = sr[RES_W-1:0] >> shamt;

  assign cs_n_o = ~act;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt     <= '0;
      pcnt        <= '0;
      bcnt        <= '0;
      sr          <= '0;
      act         <= 1'b0;
      sclk_q      <= 1'b1;
      asleep      <= 1'b0;
      pd_pend     <= 1'b0;
      wake_pend   <= 1'b0;
      kind        <= FK_DATA;
      smp_valid_o <= 1'b0;
      smp_data_o  <= '0;
    end else begin
      div_cnt     <= tick ? '0 : div_cnt + 1'b1;
      pd_pend     <= pd_pend | (pd_req_i & ~asleep);
      wake_pend   <= wake_pend | (wake_req_i & asleep);
      smp_valid_o <= 1'b0;
      if (fall) begin
        sclk_q <= 1'b0;
        sr     <= {sr[FRAME_LEN-2:0], sdata_i};
      end
      if (tick) begin
        sclk_q <= 1'b1;
        pcnt   <= (pcnt >= eff - 1'b1) ? '0 : pcnt + 1'b1;
        if (act) begin
          if (bcnt == last_bit) begin
            act <= 1'b0;
            case (kind)
              FK_DATA: begin
                smp_valid_o <= 1'b1;
                smp_data_o  <= result;
              end
              FK_PD: begin
                asleep  <= 1'b1;
                pd_pend <= 1'b0;
              end
              default: asleep <= 1'b0;
            endcase
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end else if (pcnt == '0) begin
          bcnt <= '0;
          if (asleep) begin
            if (wake_pend) begin
              act       <= 1'b1;
              kind      <= FK_WAKE;
              wake_pend <= 1'b0;
            end
          end else if (pd_pend) begin
            act     <= 1'b1;
            kind    <= FK_PD;
            pd_pend <= 1'b0;
          end else begin
            act  <= 1'b1;
            kind <= FK_DATA;
          end
        end
      end
    end
  end

  logic [LO_W-1:0]  lo_cnt;
  logic [DIV_W:0]   hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= (DIV_W + 1)'(DIV);
    end else begin
      lo_cnt <= cs_n_o ? '0 : lo_cnt + 1'b1;
      if (!cs_n_o) hi_cnt <= '0;
      else if (hi_cnt < (DIV_W + 1)'(DIV)) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> sclk_o);

  assert_frame_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> (lo_cnt == LO_W'(FRAME_LEN * DIV) || lo_cnt == LO_W'(PD_LEN * DIV)));

  assert_valid_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_o |-> $rose(cs_n_o));

  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_o |=> !smp_valid_o);

  assert_min_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> (hi_cnt >= (DIV_W + 1)'(DIV)));
endmodule

// File: tb/test_adc_capture_ctrl.sv
`timescale 1ns/1ps
module test_adc_capture_ctrl;
  localparam int DIV = 4;
  localparam int PW  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [PW-1:0] period = 8'd20;
  logic [1:0]  res = 2'b00;
  logic pd_req = 1'b0, wake_req = 1'b0, sdata = 1'b0;
  logic cs_n, sclk, smp_valid;
  logic [11:0] smp_data;

  adc_capture_ctrl #(.DIV(DIV), .PERIOD_W(PW)) i_adc_capture_ctrl (
    .clk(clk), .rst_n(rst_n), .period_i(period), .res_sel_i(res),
    .pd_req_i(pd_req), .wake_req_i(wake_req), .sdata_i(sdata),
    .cs_n_o(cs_n), .sclk_o(sclk), .smp_valid_o(smp_valid), .smp_data_o(smp_data));

  always #4 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_word(input logic [11:0] v, input logic [1:0] r);
    case (r)
      2'b01:   return {4'b0, v[9:0], 2'b0};
      2'b10:   return {4'b0, v[7:0], 4'b0};
      default: return {4'b0, v};
    endcase
  endfunction

  function automatic logic [11:0] mk_res(input logic [11:0] v, input logic [1:0] r);
    case (r)
      2'b01:   return {2'b0, v[9:0]};
      2'b10:   return {4'b0, v[7:0]};
      default: return v;
    endcase
  endfunction

  // converter model
  bit use_dir = 0;
  logic [11:0] dir_val = '0;
  logic [15:0] word;
  logic [11:0] exp_res;
  logic [1:0]  fr_res;
  int idx = -1;

  always @(negedge cs_n) begin
    logic [11:0] v;
    v = use_dir ? dir_val : 12'($urandom);
    fr_res  = res;
    word    = mk_word(v, res);
    exp_res = mk_res(v, res);
    sdata   = word[15];
    idx     = 14;
  end

  always @(posedge sclk) if (!cs_n && idx >= 0) begin
    sdata = word[idx];
    idx--;
  end

  // monitor
  localparam int K_DATA = 0, K_PD = 1, K_WAKE = 2;
  int cyc = 0, last_fall = 0, nf = 0, cur_kind = K_DATA, frames = 0, idle_viol = 0, cur_per = 20;
  bit prev_cs = 1, prev_sclk = 1, have_prev = 0, prev_data = 0, skip_sp = 0;
  bit pd_armed = 0, wake_armed = 0, sleeping = 0;

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (cs_n && !sclk) idle_viol++;
    if (prev_cs && !cs_n) begin
      frames++;
      if (sleeping) begin
        check(wake_armed, "R10 frame started while asleep", 0, 1);
        cur_kind = K_WAKE;
        wake_armed = 0;
      end else if (pd_armed) begin
        cur_kind = K_PD;
        pd_armed = 0;
      end else cur_kind = K_DATA;
      if (have_prev && prev_data && cur_kind == K_DATA && !skip_sp) begin
        int exp_sp;
        exp_sp = ((cur_per < 17) ? 17 : cur_per) * DIV;
        check(cyc - last_fall == exp_sp, (cur_per < 17) ? "R8 clamped spacing" : "R7 frame spacing",
              cyc - last_fall, exp_sp);
      end
      skip_sp = 0;
      have_prev = 1;
      prev_data = (cur_kind == K_DATA);
      last_fall = cyc;
      nf = 0;
    end
    if (!cs_n && prev_sclk && !sclk) nf++;
    if (!prev_cs && cs_n) begin
      case (cur_kind)
        K_PD: begin
          check(nf == 8, "R9 power-down burst length", nf, 8);
          check(!smp_valid, "R9 no valid after burst", smp_valid, 0);
          sleeping = 1;
        end
        K_WAKE: begin
          check(nf == 16, "R11 wake frame length", nf, 16);
          check(!smp_valid, "R11 wake result discarded", smp_valid, 0);
          sleeping = 0;
        end
        default: begin
          check(nf == 16, "R2 frame length", nf, 16);
          check(smp_valid, "R5 valid at frame end", smp_valid, 1);
          check(smp_data == exp_res, (fr_res == 2'b01 || fr_res == 2'b10) ? "R6 reduced result" : "R4 12-bit result",
                smp_data, exp_res);
        end
      endcase
    end else if (smp_valid) check(0, "R5 stray valid", 1, 0);
    prev_cs = cs_n;
    prev_sclk = sclk;
  end

  task automatic wait_valid();
    do @(negedge clk); while (!smp_valid);
  endtask

  task automatic set_period(input int p);
    cur_per = p;
    period = PW'(p);
    skip_sp = 1;
  endtask

  logic [11:0] dirs [5] = '{12'hFFF, 12'h000, 12'h800, 12'h001, 12'hA5A};

  initial begin
    void'($urandom(32'd1234));
    use_dir = 1;
    dir_val = dirs[0];
    repeat (3) @(negedge clk);
    check(cs_n && sclk && !smp_valid, "R1 state in reset", {cs_n, sclk, smp_valid}, 3'b110);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs_n && sclk && !smp_valid, "R1 state after reset", {cs_n, sclk, smp_valid}, 3'b110);
    for (int i = 0; i < 5; i++) begin
      wait_valid();
      if (i < 4) begin
        dir_val = dirs[i + 1];
        res = 2'(i + 1);
      end
    end
    use_dir = 0;
    set_period(5);
    for (int i = 0; i < 3; i++) wait_valid();
    for (int i = 0; i < 30; i++) begin
      if ($urandom % 3 == 0) set_period(5 + int'($urandom % 36));
      res = 2'($urandom);
      wait_valid();
    end
    set_period(18);
    wait_valid();
    pd_armed = 1;
    pd_req = 1'b1;
    @(negedge clk);
    pd_req = 1'b0;
    while (!sleeping) @(negedge clk);
    begin
      int f0;
      f0 = frames;
      repeat (2 * 18 * DIV) @(negedge clk);
      pd_req = 1'b1;
      @(negedge clk);
      pd_req = 1'b0;
      repeat (3 * 18 * DIV) @(negedge clk);
      check(frames == f0, "R10 idle while asleep", frames, f0);
    end
    wake_armed = 1;
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    for (int i = 0; i < 3; i++) begin
      res = 2'($urandom);
      wait_valid();
    end
    check(!sleeping, "R11 resumed after wake", sleeping, 0);
    check(idle_viol == 0, "R3 sclk idle high", idle_viol, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule